// File: doc/BRIEF.md
# Deferred Fault Poison Tracker

This block lets a pipeline hoist instructions above branches without taking a fault too early. It holds one poison flag for each architectural register. A speculative instruction can hit a fault that would end the program. When that happens, the block does not raise the fault. It poisons the instruction's destination register instead. Poison then moves through the registers. A speculative consumer of a poisoned source passes the poison on to its own result. A non-speculative consumer turns it into an exception. A check operation left at the instruction's original place in the program asks for recovery when the register it tests is poisoned.

The pipeline drives three ports. The writeback port carries the speculative flag, the fault flags and a taint flag; the taint flag says the instruction read a poisoned source. The read port has two source probes and one speculative flag for the issuing instruction, and it returns each source's poison state in the same cycle. The check port probes one register. Exceptions and recovery requests come out registered, as one-cycle pulses that carry the register index. Handling the fault and running the recovery code happen elsewhere. A resumable fault is handled at once by the pipeline, so it does not change the poison state.

Top module: `poison_tracker`

## Requirements
- R1: Reset clears every poison flag and holds `exc_o` and `rcv_o` low.
- R2: A writeback with `wb_spec_i`=1, `wb_fault_i`=1 and `wb_fatal_i`=1 poisons register `wb_rd_i` and raises no exception.
- R3: When a non-speculative read (`rd_spec_i`=0) finds a valid source poisoned, `exc_o` goes high in the next cycle for exactly that cycle, and `exc_idx_o` gives the register index.
- R4: A speculative read of a poisoned source raises no exception. A speculative writeback with `wb_taint_i`=1 and no fault poisons its destination.
- R5: A writeback with no fault and no speculative taint clears the destination's poison. Any non-speculative writeback without a fault counts as clean.
- R6: A writeback with `wb_fault_i`=1 that is not both speculative and fatal leaves the destination's poison unchanged. This covers resumable faults and non-speculative faults.
- R7: A check on a poisoned register pulses `rcv_o` in the next cycle and sets `rcv_idx_o` to that index. A check on a clean register produces no pulse.
- R8: A read or check that targets the register being written in the same cycle sees the poison state that the writeback produces.
- R9: If both non-speculative sources are poisoned, `exc_idx_o` reports source A (`rd_valid_i[0]`). While a pulse output is low, its index output is zero.
- R10: `src_nat_o[k]` is high in the same cycle only when `rd_valid_i[k]` is high and that source is poisoned. Bit 0 is source A and bit 1 is source B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wb_valid_i | input | 1 | Writeback valid |
| wb_rd_i | input | 5 | Writeback destination register |
| wb_spec_i | input | 1 | Writing instruction is speculative |
| wb_fault_i | input | 1 | Writing instruction faulted |
| wb_fatal_i | input | 1 | Fault would end the program (0 = resumable) |
| wb_taint_i | input | 1 | Instruction consumed a poisoned source |
| rd_valid_i | input | 2 | Source probe valid, bit 0 = A, bit 1 = B |
| rd_idx_a_i | input | 5 | Source A register |
| rd_idx_b_i | input | 5 | Source B register |
| rd_spec_i | input | 1 | Reading instruction is speculative |
| src_nat_o | output | 2 | Same-cycle poison state of each valid source |
| chk_valid_i | input | 1 | Check operation valid |
| chk_idx_i | input | 5 | Register tested by the check |
| exc_o | output | 1 | Deferred exception pulse |
| exc_idx_o | output | 5 | Register that caused the exception |
| rcv_o | output | 1 | Recovery request pulse |
| rcv_idx_o | output | 5 | Register that triggered recovery |

## Verification
The bench puts writebacks and reads on the same register in the same cycle. A design without the bypass would lag one cycle behind and miss a fresh poison or report a stale one. It tries each fault combination on the writeback. A design that poisons on resumable faults, or clears poison on non-speculative faults, would raise later exceptions when none is due, or fail to raise them when one is. It also uses tainted speculative writes and dual-poisoned reads, which expose broken poison propagation, a wrong source priority, and index outputs that stay nonzero between pulses.

// File: rtl/poison_pkg.sv
package poison_pkg;
  parameter int unsigned DEF_NUM_REGS = 32;
  parameter int unsigned NUM_PROBES   = 3;  // src A, src B, check

  typedef struct packed {
    logic upd;
    logic nat;
  } wb_eff_t;

  // Only a completed write updates the flag; a deferred fatal fault completes as poison.
  function automatic wb_eff_t wb_decode(logic valid, logic spec, logic fault,
                                        logic fatal, logic taint);
    wb_eff_t e;
    e.upd = valid & ~(fault & ~(spec & fatal));
    e.nat = spec & (fault | taint);
    return e;
  endfunction
endpackage

// File: rtl/poison_file.sv
module poison_file #(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [IDX_W-1:0]    widx_i,
  input  logic                wnat_i,
  output logic [NUM_REGS-1:0] nat_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   nat_o[g] <= 1'b0;
      else if (we_i && widx_i == IDX_W'(g))          nat_o[g] <= wnat_i;
    end
  end
endmodule

// File: rtl/poison_lookup.sv
module poison_lookup #(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0] nat_i,
  input  logic                we_i,
  input  logic [IDX_W-1:0]    widx_i,
  input  logic                wnat_i,
  input  logic                valid_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic                hit_o
);
  logic stored;
  always_comb begin
    stored = nat_i[idx_i];
    // bypass the write in flight
    if (we_i && widx_i == idx_i) stored = wnat_i;
    hit_o = valid_i & stored;
  end
endmodule

// File: rtl/poison_tracker.sv
module poison_tracker
  import poison_pkg::*;
#(
  parameter int unsigned NUM_REGS = DEF_NUM_REGS,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wb_valid_i,
  input  logic [IDX_W-1:0] wb_rd_i,
  input  logic             wb_spec_i,
  input  logic             wb_fault_i,
  input  logic             wb_fatal_i,
  input  logic             wb_taint_i,
  input  logic [1:0]       rd_valid_i,
  input  logic [IDX_W-1:0] rd_idx_a_i,
  input  logic [IDX_W-1:0] rd_idx_b_i,
  input  logic             rd_spec_i,
  output logic [1:0]       src_nat_o,
  input  logic             chk_valid_i,
  input  logic [IDX_W-1:0] chk_idx_i,
  output logic             exc_o,
  output logic [IDX_W-1:0] exc_idx_o,
  output logic             rcv_o,
  output logic [IDX_W-1:0] rcv_idx_o
);
  wb_eff_t             wb_eff;
  logic [NUM_REGS-1:0] nat_q;
  logic [NUM_PROBES-1:0]            pr_valid, pr_hit;
  logic [NUM_PROBES-1:0][IDX_W-1:0] pr_idx;

  assign wb_eff = wb_decode(wb_valid_i, wb_spec_i, wb_fault_i, wb_fatal_i, wb_taint_i);

  poison_file #(.NUM_REGS(NUM_REGS)) u_file (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wb_eff.upd),
    .widx_i (wb_rd_i),
    .wnat_i (wb_eff.nat),
    .nat_o  (nat_q)
  );

  assign pr_valid = {chk_valid_i, rd_valid_i[1], rd_valid_i[0]};
  assign pr_idx   = {chk_idx_i, rd_idx_b_i, rd_idx_a_i};

  for (genvar p = 0; p < NUM_PROBES; p++) begin : g_probe
    poison_lookup #(.NUM_REGS(NUM_REGS)) u_lk (
      .nat_i   (nat_q),
      .we_i    (wb_eff.upd),
      .widx_i  (wb_rd_i),
      .wnat_i  (wb_eff.nat),
      .valid_i (pr_valid[p]),
      .idx_i   (pr_idx[p]),
      .hit_o   (pr_hit[p])
    );
  end

  assign src_nat_o = pr_hit[1:0];

  logic             exc_d, rcv_d;
  logic [IDX_W-1:0] exc_idx_d, rcv_idx_d;

  always_comb begin
    exc_d     = ~rd_spec_i & (|pr_hit[1:0]);
    exc_idx_d = '0;
    if (exc_d) exc_idx_d = pr_hit[0] ? rd_idx_a_i : rd_idx_b_i;  // A wins
    rcv_d     = pr_hit[2];
    rcv_idx_d = rcv_d ? chk_idx_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_o     <= 1'b0;
      exc_idx_o <= '0;
      rcv_o     <= 1'b0;
      rcv_idx_o <= '0;
    end else begin
      exc_o     <= exc_d;
      exc_idx_o <= exc_idx_d;
      rcv_o     <= rcv_d;
      rcv_idx_o <= rcv_idx_d;
    end
  end
endmodule

// File: rtl/poison_tracker_chk.sv
module poison_tracker_chk #(
  parameter int unsigned IDX_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wb_valid_i,
  input logic [IDX_W-1:0] wb_rd_i,
  input logic             wb_spec_i,
  input logic             wb_fault_i,
  input logic             wb_fatal_i,
  input logic             wb_taint_i,
  input logic [1:0]       rd_valid_i,
  input logic [IDX_W-1:0] rd_idx_a_i,
  input logic [IDX_W-1:0] rd_idx_b_i,
  input logic             rd_spec_i,
  input logic [1:0]       src_nat_o,
  input logic             chk_valid_i,
  input logic [IDX_W-1:0] chk_idx_i,
  input logic             exc_o,
  input logic [IDX_W-1:0] exc_idx_o,
  input logic             rcv_o,
  input logic [IDX_W-1:0] rcv_idx_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_quiet_r1: assert (!exc_o && !rcv_o);
  end

  // deferred fatal write is visible to a same-cycle probe of that register
  p_defer_bypass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && wb_spec_i && wb_fault_i && wb_fatal_i && rd_valid_i[0] && rd_idx_a_i == wb_rd_i)
      |-> src_nat_o[0]);

  p_exc_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> ($past(|src_nat_o) && !$past(rd_spec_i)));

  p_spec_silent_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_spec_i |=> !exc_o);

  p_rcv_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rcv_o |-> ($past(chk_valid_i) && rcv_idx_o == $past(chk_idx_i)));

  p_idx_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exc_o |-> exc_idx_o == '0) and (!rcv_o |-> rcv_idx_o == '0));

  p_nat_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_nat_o & ~rd_valid_i) == 2'b00));
endmodule

bind poison_tracker poison_tracker_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_poison_tracker.sv
`timescale 1ns/1ps
module sim_poison_tracker;
  localparam int N = 32;
  localparam int W = 5;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wb_valid_i, wb_spec_i, wb_fault_i, wb_fatal_i, wb_taint_i;
  logic [W-1:0] wb_rd_i, rd_idx_a_i, rd_idx_b_i, chk_idx_i;
  logic [1:0] rd_valid_i, src_nat_o;
  logic rd_spec_i, chk_valid_i, exc_o, rcv_o;
  logic [W-1:0] exc_idx_o, rcv_idx_o;

  always #2.5 clk_i = ~clk_i;

  poison_tracker u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [N-1:0] model;
  logic exp_exc, exp_rcv;
  logic [W-1:0] exp_exc_idx, exp_rcv_idx;
  string tag;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic wb_upd();
    return wb_valid_i & ~(wb_fault_i & ~(wb_spec_i & wb_fatal_i));
  endfunction
  function automatic logic wb_nat();
    return wb_spec_i & (wb_fault_i | wb_taint_i);
  endfunction
  function automatic logic eff(logic [W-1:0] i);
    if (wb_upd() && wb_rd_i == i) return wb_nat();
    return model[i];
  endfunction

  // inputs already driven after negedge; checks comb, then registered after edge
  task automatic cycle_eval();
    logic pa, pb, pc;
    #1;
    pa = rd_valid_i[0] & eff(rd_idx_a_i);
    pb = rd_valid_i[1] & eff(rd_idx_b_i);
    pc = chk_valid_i & eff(chk_idx_i);
    chk((tag == "") ? "R10" : tag, "src_nat", src_nat_o, {pb, pa});
    exp_exc = ~rd_spec_i & (pa | pb);
    exp_exc_idx = !exp_exc ? '0 : (pa ? rd_idx_a_i : rd_idx_b_i);
    exp_rcv = pc;
    exp_rcv_idx = pc ? chk_idx_i : '0;
    if (wb_upd()) model[wb_rd_i] = wb_nat();
    @(posedge clk_i); #1;
    chk((tag == "") ? "R3" : tag, "exc", exc_o, exp_exc);
    chk((tag == "") ? "R9" : tag, "exc_idx", exc_idx_o, exp_exc_idx);
    chk((tag == "") ? "R7" : tag, "rcv", rcv_o, exp_rcv);
    chk((tag == "") ? "R7" : tag, "rcv_idx", rcv_idx_o, exp_rcv_idx);
  endtask

  task automatic idle();
    wb_valid_i = 0; wb_rd_i = 0; wb_spec_i = 0; wb_fault_i = 0; wb_fatal_i = 0; wb_taint_i = 0;
    rd_valid_i = 0; rd_idx_a_i = 0; rd_idx_b_i = 0; rd_spec_i = 0; chk_valid_i = 0; chk_idx_i = 0;
  endtask

  task automatic wb(int rd, bit spec, bit fault, bit fatal, bit taint);
    wb_valid_i = 1; wb_rd_i = W'(rd); wb_spec_i = spec; wb_fault_i = fault;
    wb_fatal_i = fatal; wb_taint_i = taint;
  endtask
  task automatic rd(bit va, int a, bit vb, int b, bit spec);
    rd_valid_i = {vb, va}; rd_idx_a_i = W'(a); rd_idx_b_i = W'(b); rd_spec_i = spec;
  endtask
  task automatic ck(int i);
    chk_valid_i = 1; chk_idx_i = W'(i);
  endtask
  task automatic go();
    cycle_eval(); @(negedge clk_i); idle();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    idle(); model = '0; tag = "R1";
    #12;
    chk("R1", "exc in reset", exc_o, 0);
    chk("R1", "rcv in reset", rcv_o, 0);
    @(negedge clk_i); rst_ni = 1;
    // R1: every flag clear after reset
    for (int i = 0; i < N / 2; i++) begin rd(1, 2*i, 1, 2*i+1, 1); go(); end
    tag = "R2"; wb(5, 1, 1, 1, 0); go();
    tag = "R4"; rd(1, 5, 0, 0, 1); go();            // spec read: no exception
    tag = "R3"; rd(1, 5, 0, 0, 0); go();            // exc idx 5
    tag = "R4"; wb(7, 1, 0, 0, 1); go();            // taint propagates
    tag = "R4"; rd(0, 0, 1, 7, 0); go();            // exc idx 7
    tag = "R9"; rd(1, 7, 1, 5, 0); go();            // A wins -> 7
    tag = "R9"; rd(1, 1, 1, 5, 0); go();            // -> 5
    tag = "R7"; ck(5); go();
    tag = "R7"; ck(1); go();
    tag = "R5"; wb(5, 0, 0, 0, 0); go();
    tag = "R5"; rd(1, 5, 0, 0, 0); go();
    tag = "R6"; wb(7, 1, 1, 0, 0); go();            // resumable: stays poisoned
    tag = "R6"; wb(7, 0, 1, 1, 0); go();            // non-spec fault: unchanged
    tag = "R6"; ck(7); go();
    tag = "R8"; wb(9, 1, 1, 1, 0); rd(1, 9, 1, 9, 0); go();
    tag = "R8"; wb(7, 0, 0, 0, 0); ck(7); go();
    tag = "R8"; wb(9, 0, 0, 0, 0); rd(0, 0, 1, 9, 0); ck(9); go();
    tag = "";
    for (int c = 0; c < 3000; c++) begin
      bit narrow = ($urandom % 2) == 0;
      int m = narrow ? 4 : N;
      wb_valid_i = $urandom % 2; wb_rd_i = W'($urandom % m);
      wb_spec_i = $urandom % 2; wb_fault_i = ($urandom % 3) == 0;
      wb_fatal_i = $urandom % 2; wb_taint_i = ($urandom % 3) == 0;
      rd_valid_i = 2'($urandom); rd_idx_a_i = W'($urandom % m); rd_idx_b_i = W'($urandom % m);
      rd_spec_i = $urandom % 2; chk_valid_i = $urandom % 2; chk_idx_i = W'($urandom % m);
      go();
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule